// File: doc/BRIEF.md
# Audio Converter Control Register Bank

This block holds the control settings of a multichannel audio converter. A host delivers 16-bit control words on a parallel port, each qualified by a valid strobe. Every word carries a register address and a 9-bit value. The bank decodes each word, updates the registers it owns, and drives the stored settings straight to the converter datapath. The settings are the per-channel digital gain codes, the per-channel polarity inversion, the per-converter enables and a global mute. No read path exists.

The gain registers are organised as left/right pairs. A plain write to a gain register only changes a hidden pending code. A write that sets the update flag moves the pending codes of both channels of its pair into the active gains together. Both channels therefore always change on the same clock edge. A write to the top address restores every register to its default, and words aimed beyond the register space are dropped and flagged.

Top module: `acodec_ctrl_regs`

## Requirements
- R1: A word is taken on a rising clock edge only while `wr_valid` is high; bits 15:9 are the address and bits 8:0 the data; a word presented with `wr_valid` low changes nothing.
- R2: A synchronous active-high `rst` sets all pending and active gain codes to 0xFF, all invert bits to 0, all converter enables to 1 and the global mute to 0.
- R3: An accepted word at address 0x35 has exactly the effect of `rst`, whatever its data bits hold.
- R4: A word at a gain address (0x14 + 2p for the left channel of pair p, 0x15 + 2p for the right) with data bit 8 clear stores bits 7:0 as that channel's pending code and leaves every `gain_o` field unchanged.
- R5: A gain word with data bit 8 set stores its code as pending and, on the same edge, copies the pending codes of both channels of that pair into their active gains; other pairs keep their gains. Channel c = 2p + side (left 0, right 1) appears at `gain_o[8c+7:8c]`.
- R6: A word at address 0x12 loads data bits 5:0 into `inv_o`, bit c belonging to channel c. A word at 0x13 loads data bits 2:0 into `dac_en_o`, bit p belonging to pair p.
- R7: Data bit 4 of a word at 0x13 sets `mute_all_o`, and while it is set every bit of `ch_mute_o` is 1.
- R8: Bit c of `ch_mute_o` is also 1 when the active gain code of channel c is 0x00 or when the enable of its pair is 0, and it is 0 otherwise.
- R9: An accepted word whose address exceeds 0x35 changes no register, and `wr_err_o` is 1 for exactly the one cycle after the edge that took it.
- R10: An accepted word at any address up to 0x34 that is not a gain, invert or control address changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Qualifies `wr_word` |
| wr_word | input | 16 | Address in 15:9, data in 8:0 |
| gain_o | output | 16*NUM_PAIRS | Active gain codes, 8 bits per channel |
| inv_o | output | 2*NUM_PAIRS | Polarity inversion per channel |
| dac_en_o | output | NUM_PAIRS | Enable per converter pair |
| mute_all_o | output | 1 | Global mute setting |
| ch_mute_o | output | 2*NUM_PAIRS | Effective mute per channel |
| wr_err_o | output | 1 | One-cycle pulse for an out-of-range address |

## Verification
The hardest situation to reach is an update commit that carries a pending code the host wrote to the other channel of the pair much earlier. That code is invisible at the ports until the commit. The bench therefore loads a pending code on one side, checks that the gains have not moved, and then commits from the opposite side with a different code. It sweeps this pattern over every channel and over the extreme codes 0x00, 0x01, 0x7F, 0x80, 0xFE and 0xFF. A full sweep over all 128 addresses starts from a non-default state, so that an unwanted change or a missing error pulse shows up at the outputs.

// File: rtl/acodec_ctrl_pkg.sv
package acodec_ctrl_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 9;
    localparam int CODE_W = 8;
    localparam int WORD_W = ADDR_W + DATA_W;

    // Address map decoded by the bank
    localparam logic [ADDR_W-1:0] ADDR_GAIN_BASE = 7'h14;
    localparam logic [ADDR_W-1:0] ADDR_INVERT    = 7'h12;
    localparam logic [ADDR_W-1:0] ADDR_CONTROL   = 7'h13;
    localparam logic [ADDR_W-1:0] ADDR_BANK_RST  = 7'h35;
    localparam logic [ADDR_W-1:0] ADDR_LAST      = 7'h35;

    localparam int UPDATE_BIT = 8;
    localparam int MUTE_BIT   = 4;

    localparam logic [CODE_W-1:0] GAIN_DEFAULT = 8'hFF;

    typedef struct packed {
        logic [CODE_W-1:0] pend_l;
        logic [CODE_W-1:0] pend_r;
        logic [CODE_W-1:0] act_l;
        logic [CODE_W-1:0] act_r;
    } pair_state_t;
endpackage

// File: rtl/acodec_ctrl_decode.sv
module acodec_ctrl_decode
    import acodec_ctrl_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic                   wr_valid,
    input  logic [WORD_W-1:0]      wr_word,
    output logic [2*NUM_PAIRS-1:0] gain_we,
    output logic                   inv_we,
    output logic                   ctl_we,
    output logic                   bank_rst,
    output logic                   bad_addr,
    output logic [DATA_W-1:0]      wr_data
);
    logic [ADDR_W-1:0] addr;

    assign addr    = wr_word[WORD_W-1:DATA_W];
    assign wr_data = wr_word[DATA_W-1:0];

    always_comb begin
        inv_we   = wr_valid && (addr == ADDR_INVERT);
        ctl_we   = wr_valid && (addr == ADDR_CONTROL);
        bank_rst = wr_valid && (addr == ADDR_BANK_RST);
        bad_addr = wr_valid && (addr > ADDR_LAST);
    end

    // One strobe per gain channel
    for (genvar c = 0; c < 2*NUM_PAIRS; c++) begin : g_gain_dec
        assign gain_we[c] = wr_valid && (addr == ADDR_GAIN_BASE + ADDR_W'(c));
    end
endmodule

// File: rtl/acodec_gain_pair.sv
module acodec_gain_pair
    import acodec_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              clear,
    input  logic              we_l,
    input  logic              we_r,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CODE_W-1:0] gain_l,
    output logic [CODE_W-1:0] gain_r
);
    pair_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.pend_l = GAIN_DEFAULT;
            st_d.pend_r = GAIN_DEFAULT;
            st_d.act_l  = GAIN_DEFAULT;
            st_d.act_r  = GAIN_DEFAULT;
        end else begin
            if (we_l) st_d.pend_l = wr_data[CODE_W-1:0];
            if (we_r) st_d.pend_r = wr_data[CODE_W-1:0];
            // Commit both sides together, using the freshly written code
            if ((we_l || we_r) && wr_data[UPDATE_BIT]) begin
                st_d.act_l = st_d.pend_l;
                st_d.act_r = st_d.pend_r;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign gain_l = st_q.act_l;
    assign gain_r = st_q.act_r;
endmodule

// File: rtl/acodec_ctrl_regs.sv
module acodec_ctrl_regs
    import acodec_ctrl_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_valid,
    input  logic [15:0]                   wr_word,
    output logic [2*NUM_PAIRS*CODE_W-1:0] gain_o,
    output logic [2*NUM_PAIRS-1:0]        inv_o,
    output logic [NUM_PAIRS-1:0]          dac_en_o,
    output logic                          mute_all_o,
    output logic [2*NUM_PAIRS-1:0]        ch_mute_o,
    output logic                          wr_err_o
);
    localparam int NUM_CH = 2 * NUM_PAIRS;

    typedef struct packed {
        logic [NUM_CH-1:0]    inv;
        logic [NUM_PAIRS-1:0] en;
        logic                 mute;
        logic                 err;
    } ctl_state_t;

    logic [NUM_CH-1:0] gain_we;
    logic              inv_we, ctl_we, bank_rst, bad_addr, clear;
    logic [DATA_W-1:0] wr_data;

    ctl_state_t s_d, s_q;

    acodec_ctrl_decode #(.NUM_PAIRS(NUM_PAIRS)) dec_i (
        .wr_valid (wr_valid),
        .wr_word  (wr_word),
        .gain_we  (gain_we),
        .inv_we   (inv_we),
        .ctl_we   (ctl_we),
        .bank_rst (bank_rst),
        .bad_addr (bad_addr),
        .wr_data  (wr_data)
    );

    assign clear = rst || bank_rst;

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        acodec_gain_pair pair_i (
            .clk     (clk),
            .clear   (clear),
            .we_l    (gain_we[2*p]),
            .we_r    (gain_we[2*p+1]),
            .wr_data (wr_data),
            .gain_l  (gain_o[(2*p)*CODE_W +: CODE_W]),
            .gain_r  (gain_o[(2*p+1)*CODE_W +: CODE_W])
        );
    end

    always_comb begin
        s_d     = s_q;
        s_d.err = bad_addr && !rst;
        if (clear) begin
            s_d.inv  = '0;
            s_d.en   = '1;
            s_d.mute = 1'b0;
        end else if (inv_we) begin
            s_d.inv = wr_data[NUM_CH-1:0];
        end else if (ctl_we) begin
            s_d.en   = wr_data[NUM_PAIRS-1:0];
            s_d.mute = wr_data[MUTE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign inv_o      = s_q.inv;
    assign dac_en_o   = s_q.en;
    assign mute_all_o = s_q.mute;
    assign wr_err_o   = s_q.err;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_mute
        assign ch_mute_o[c] = s_q.mute || !s_q.en[c/2]
                              || (gain_o[c*CODE_W +: CODE_W] == '0);
    end
endmodule

// File: rtl/acodec_ctrl_regs_chk.sv
module acodec_ctrl_regs_chk
    import acodec_ctrl_pkg::*;
#(
    parameter int NUM_PAIRS = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          wr_valid,
    input logic [15:0]                   wr_word,
    input logic [2*NUM_PAIRS*CODE_W-1:0] gain_o,
    input logic [2*NUM_PAIRS-1:0]        inv_o,
    input logic [NUM_PAIRS-1:0]          dac_en_o,
    input logic                          mute_all_o,
    input logic [2*NUM_PAIRS-1:0]        ch_mute_o,
    input logic                          wr_err_o
);
    localparam logic [ADDR_W-1:0] GAIN_END = ADDR_GAIN_BASE + ADDR_W'(2*NUM_PAIRS);
    localparam logic [2*NUM_PAIRS*CODE_W-1:0] GAINS_DEF = {2*NUM_PAIRS{GAIN_DEFAULT}};

    logic [ADDR_W-1:0] a;
    logic bad_w, rst_w, hold_w;
    assign a      = wr_word[15:9];
    assign bad_w  = wr_valid && (a > ADDR_LAST);
    assign rst_w  = wr_valid && (a == ADDR_BANK_RST);
    assign hold_w = wr_valid && (a >= ADDR_GAIN_BASE) && (a < GAIN_END) && !wr_word[UPDATE_BIT];

    assert_reset_defaults_R2: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (gain_o == GAINS_DEF) && (inv_o == '0) && (&dac_en_o) && !mute_all_o);

    assert_bank_reset_R3: assert property (@(posedge clk) disable iff (rst)
        rst_w |=> (gain_o == GAINS_DEF) && (inv_o == '0) && (&dac_en_o) && !mute_all_o);

    assert_pending_hold_R4: assert property (@(posedge clk) disable iff (rst)
        hold_w |=> $stable(gain_o));

    assert_mute_all_R7: assert property (@(posedge clk) disable iff (rst)
        mute_all_o |-> (&ch_mute_o));

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        bad_w |=> wr_err_o);

    assert_err_cause_R9: assert property (@(posedge clk) disable iff (rst)
        wr_err_o |-> $past(bad_w));

    assert_bad_no_effect_R9: assert property (@(posedge clk) disable iff (rst)
        bad_w |=> $stable(gain_o) && $stable(inv_o) && $stable(dac_en_o) && $stable(mute_all_o));
endmodule

bind acodec_ctrl_regs acodec_ctrl_regs_chk #(.NUM_PAIRS(NUM_PAIRS)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_valid   (wr_valid),
    .wr_word    (wr_word),
    .gain_o     (gain_o),
    .inv_o      (inv_o),
    .dac_en_o   (dac_en_o),
    .mute_all_o (mute_all_o),
    .ch_mute_o  (ch_mute_o),
    .wr_err_o   (wr_err_o)
);

// File: tb/acodec_ctrl_regs_tb_top.sv
`timescale 1ns/1ps
module acodec_ctrl_regs_tb_top;
    localparam int NP  = 3;
    localparam int NCH = 2 * NP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_valid = 1'b0;
    logic [15:0] wr_word = '0;
    logic [NCH*8-1:0] gain_o;
    logic [NCH-1:0] inv_o, ch_mute_o;
    logic [NP-1:0] dac_en_o;
    logic mute_all_o, wr_err_o;

    always #2 clk = ~clk;

    acodec_ctrl_regs #(.NUM_PAIRS(NP)) dut_i (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_word(wr_word),
        .gain_o(gain_o), .inv_o(inv_o), .dac_en_o(dac_en_o),
        .mute_all_o(mute_all_o), .ch_mute_o(ch_mute_o), .wr_err_o(wr_err_o)
    );

    int checks = 0;
    int errors = 0;

    // Reference state derived from the requirements
    logic [7:0] m_pend [NCH];
    logic [7:0] m_act  [NCH];
    logic [NCH-1:0] m_inv;
    logic [NP-1:0]  m_en;
    logic m_mute;
    logic m_err;

    task automatic model_defaults();
        for (int c = 0; c < NCH; c++) begin
            m_pend[c] = 8'hFF;
            m_act[c]  = 8'hFF;
        end
        m_inv = '0; m_en = '1; m_mute = 1'b0;
    endtask

    task automatic model_write(input logic [6:0] a, input logic [8:0] d);
        m_err = 1'b0;
        if (a == 7'h35) model_defaults();
        else if (a > 7'h35) m_err = 1'b1;
        else if (a >= 7'h14 && a < 7'h14 + 7'(NCH)) begin
            int c = int'(a) - 'h14;
            int p = c / 2;
            m_pend[c] = d[7:0];
            if (d[8]) begin
                m_act[2*p]   = m_pend[2*p];
                m_act[2*p+1] = m_pend[2*p+1];
            end
        end else if (a == 7'h12) m_inv = d[NCH-1:0];
        else if (a == 7'h13) begin
            m_en = d[NP-1:0];
            m_mute = d[4];
        end
    endtask

    task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        logic [NCH-1:0] em;
        for (int c = 0; c < NCH; c++) begin
            chk(req, "gain", 48'(gain_o[c*8 +: 8]), 48'(m_act[c]));
            em[c] = m_mute | ~m_en[c/2] | (m_act[c] == 8'h00);
        end
        chk(req, "inv", 48'(inv_o), 48'(m_inv));
        chk(req, "en", 48'(dac_en_o), 48'(m_en));
        chk(req, "mute_all", 48'(mute_all_o), 48'(m_mute));
        chk(req, "ch_mute", 48'(ch_mute_o), 48'(em));
        chk(req, "err", 48'(wr_err_o), 48'(m_err));
    endtask

    // Present at a falling edge, taken at the rising edge, sampled at the next falling edge
    task automatic do_write(input logic [6:0] a, input logic [8:0] d, input string req);
        wr_valid = 1'b1;
        wr_word  = {a, d};
        @(negedge clk);
        wr_valid = 1'b0;
        wr_word  = '0;
        model_write(a, d);
        check_all(req);
        m_err = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_defaults();
        m_err = 1'b0;
    endtask

    initial begin
        logic [7:0] codes [7];
        codes[0] = 8'h00; codes[1] = 8'h01; codes[2] = 8'h7F; codes[3] = 8'h80;
        codes[4] = 8'hFE; codes[5] = 8'hFF; codes[6] = 8'h3C;
        model_defaults();
        m_err = 1'b0;
        @(negedge clk);
        do_reset();
        check_all("R2");

        // R4 then R5: pend one side, commit from the partner side
        for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k < 7; k++) begin
                int partner = c ^ 1;
                do_write(7'h14 + 7'(c), {1'b0, codes[k]}, "R4");
                do_write(7'h14 + 7'(partner), {1'b1, codes[k] ^ 8'h5A}, "R5");
            end
        end

        // R6 invert sweep
        for (int v = 0; v < 64; v++) do_write(7'h12, 9'(v), "R6");
        // R6 R7 R8 control sweep, including zero gain on pair 0
        do_write(7'h14, 9'h000, "R4");
        do_write(7'h15, 9'h1FF, "R5");
        for (int v = 0; v < 32; v++) do_write(7'h13, 9'(v) | 9'h0E0, (v & 16) != 0 ? "R7" : "R8");

        // R9 and R10: full address sweep from a non-default state
        do_write(7'h12, 9'h015, "R6");
        do_write(7'h13, 9'h005, "R6");
        do_write(7'h16, 9'h144, "R5");
        for (int a = 0; a < 128; a++) begin
            if (a == 'h35) continue;
            do_write(7'(a), 9'h0AA, a > 'h35 ? "R9" : "R10");
            @(negedge clk);
            check_all("R9");
        end

        // R1: word with valid low
        wr_word = {7'h12, 9'h03F};
        @(negedge clk);
        @(negedge clk);
        wr_word = '0;
        check_all("R1");

        // R3: bank reset by write, data all ones
        do_write(7'h18, 9'h011, "R4");
        do_write(7'h35, 9'h1FF, "R3");
        do_write(7'h19, 9'h122, "R3");

        // R2: hardware reset from a modified state
        do_write(7'h13, 9'h010, "R7");
        do_write(7'h12, 9'h02A, "R6");
        do_reset();
        check_all("R2");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule